// File: doc/BRIEF.md
# Core Standby and Debug-Wake Controller

This controller tracks a processor core through its wait-for-interrupt standby state and decides how each wake source is handled. A standby request moves the core from running into standby. Three events end or interrupt standby. An unmasked interrupt wakes the core, retires the pending wait instruction and returns to running. A halting debug event wakes the core, retires the wait instruction and then places the core in debug state. A debug-port access on the APB only borrows the core: the controller wakes it, holds the bus ready low until the wake-up has finished, completes the transfer and puts the core back into standby without retiring the wait instruction.

The wake-up lasts a fixed number of cycles set by a parameter. Standby itself keeps every piece of core state. The controller has no path that clears or resets debug settings. Clock gating, power switching and the debug register file are not part of this block.

Top module: `core_standby_ctrl`

## Requirements
- R1: While and after synchronous reset, the core is running: standby, retire, debug-state and ready outputs are all 0.
- R2: A standby request while running raises the standby output on the next cycle. It stays high, and repeated requests have no effect, until a wake event arrives.
- R3: A halting debug event in standby drops the standby output on the next cycle. The retire output then pulses after WAKE_CYC wake cycles, and the debug-state output rises on the cycle after the pulse.
- R4: An APB access (select high) in standby starts a wake of WAKE_CYC cycles with ready low. Ready is high for exactly the following cycle, then standby returns and retire stays 0.
- R5: An unmasked interrupt in standby wakes the core for WAKE_CYC cycles, pulses retire for one cycle, and returns to running with debug state 0.
- R6: When a halting event and an APB access arrive in the same standby cycle, the halting path is taken. The access is completed later in debug state, not through a return to standby.
- R7: In debug state a standby request is ignored: debug state stays 1 and standby stays 0 until a resume input returns the core to running.
- R8: While running or in debug state, an APB access phase (select and enable high) is answered with ready high on the next cycle, for one cycle.
- R9: A halting event that arrives during a temporary debug-access wake is remembered. After the access completes, retire pulses and debug state follows without re-entering standby.
- R10: Retire is never high on two cycles in a row, and standby and debug state are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wfi_req_i | input | 1 | Request to enter standby (wait instruction issued) |
| irq_wake_i | input | 1 | Unmasked interrupt wake request |
| halt_evt_i | input | 1 | Halting debug event |
| dbg_resume_i | input | 1 | Leave debug state and run |
| apb_psel_i | input | 1 | Debug APB select |
| apb_penable_i | input | 1 | Debug APB enable (access phase) |
| apb_pready_o | output | 1 | Debug APB ready, registered |
| standby_o | output | 1 | Core is in standby |
| wfi_retire_o | output | 1 | One-cycle pulse: wait instruction retired |
| debug_state_o | output | 1 | Core is in debug state |

## Verification
The checker watches every cycle for the properties that hold regardless of the stimulus. It checks that standby and debug state are exclusive and that retire is a one-cycle pulse. It checks that ready is never given in standby, and that a served access lasted exactly WAKE_CYC wake cycles. It also checks that each retire leads to the right next state and that debug state persists until resume. The bench scenarios show the ordering and priority behaviour that needs a specific stimulus: a halt and an access arriving together, a halt arriving in the middle of a temporary wake, and a standby request ignored in debug state.

// File: rtl/csw_pkg.sv
package csw_pkg;
  typedef enum logic [3:0] {
    S_RUN   = 4'd0,
    S_STBY  = 4'd1,
    S_WAKEA = 4'd2,  // temporary wake for a debug access
    S_SERVE = 4'd3,  // access completes, ready high
    S_WAKEH = 4'd4,  // wake for halting event
    S_WAKEI = 4'd5,  // wake for interrupt
    S_RETD  = 4'd6,  // retire, then debug
    S_RETR  = 4'd7,  // retire, then run
    S_DEBUG = 4'd8
  } csw_state_e;
endpackage

// File: rtl/csw_wake_timer.sv
module csw_wake_timer #(
  parameter int WAKE_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic done_o
);
  localparam int CW = (WAKE_CYC > 1) ? $clog2(WAKE_CYC) : 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (start_i) begin
      cnt_q <= CW'(WAKE_CYC - 1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/csw_fsm.sv
module csw_fsm
  import csw_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wfi_req_i,
  input  logic       irq_i,
  input  logic       halt_i,
  input  logic       resume_i,
  input  logic       psel_i,
  input  logic       pready_i,
  input  logic       wake_done_i,
  output logic       wake_start_o,
  output logic       serve_next_o,
  output logic       awake_o,
  output csw_state_e state_o
);
  csw_state_e state_q, state_d;
  logic       halt_pend_q;

  always_comb begin
    state_d      = state_q;
    wake_start_o = 1'b0;
    unique case (state_q)
      S_RUN: begin
        if (halt_i)         state_d = S_DEBUG;
        else if (wfi_req_i) state_d = S_STBY;
      end
      S_STBY: begin
        if (halt_i) begin
          state_d = S_WAKEH;  wake_start_o = 1'b1;
        end else if (psel_i && !pready_i) begin
          state_d = S_WAKEA;  wake_start_o = 1'b1;
        end else if (irq_i) begin
          state_d = S_WAKEI;  wake_start_o = 1'b1;
        end
      end
      S_WAKEA: if (wake_done_i) state_d = S_SERVE;
      S_WAKEH: if (wake_done_i) state_d = S_RETD;
      S_WAKEI: if (wake_done_i) state_d = S_RETR;
      S_SERVE: begin
        if (halt_pend_q || halt_i) state_d = S_RETD;
        else if (irq_i)            state_d = S_RETR;
        else                       state_d = S_STBY;
      end
      S_RETD:  state_d = S_DEBUG;
      S_RETR:  state_d = S_RUN;
      S_DEBUG: if (resume_i) state_d = S_RUN;
      default: state_d = S_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= S_RUN;
      halt_pend_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      halt_pend_q <= (state_q == S_WAKEA) && (halt_pend_q || halt_i);
    end
  end

  assign serve_next_o = (state_d == S_SERVE);
  assign awake_o      = (state_q == S_RUN) || (state_q == S_DEBUG);
  assign state_o      = state_q;
endmodule

// File: rtl/csw_apb_ready.sv
module csw_apb_ready (
  input  logic clk,
  input  logic rst,
  input  logic awake_i,
  input  logic serve_next_i,
  input  logic psel_i,
  input  logic penable_i,
  output logic pready_o
);
  logic rdy_q;

  always_ff @(posedge clk) begin
    if (rst) rdy_q <= 1'b0;
    else     rdy_q <= serve_next_i ||
                      (awake_i && psel_i && penable_i && !rdy_q);
  end

  assign pready_o = rdy_q;
endmodule

// File: rtl/core_standby_ctrl.sv
module core_standby_ctrl
  import csw_pkg::*;
#(
  parameter int WAKE_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic wfi_req_i,
  input  logic irq_wake_i,
  input  logic halt_evt_i,
  input  logic dbg_resume_i,
  input  logic apb_psel_i,
  input  logic apb_penable_i,
  output logic apb_pready_o,
  output logic standby_o,
  output logic wfi_retire_o,
  output logic debug_state_o
);
  logic       wake_start, wake_done, serve_next, awake;
  csw_state_e fsm_state;

  csw_wake_timer #(.WAKE_CYC(WAKE_CYC)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .start_i (wake_start),
    .done_o  (wake_done)
  );

  csw_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .wfi_req_i    (wfi_req_i),
    .irq_i        (irq_wake_i),
    .halt_i       (halt_evt_i),
    .resume_i     (dbg_resume_i),
    .psel_i       (apb_psel_i),
    .pready_i     (apb_pready_o),
    .wake_done_i  (wake_done),
    .wake_start_o (wake_start),
    .serve_next_o (serve_next),
    .awake_o      (awake),
    .state_o      (fsm_state)
  );

  csw_apb_ready u_rdy (
    .clk          (clk),
    .rst          (rst),
    .awake_i      (awake),
    .serve_next_i (serve_next),
    .psel_i       (apb_psel_i),
    .penable_i    (apb_penable_i),
    .pready_o     (apb_pready_o)
  );

  assign standby_o     = (fsm_state == S_STBY);
  assign wfi_retire_o  = (fsm_state == S_RETD) || (fsm_state == S_RETR);
  assign debug_state_o = (fsm_state == S_DEBUG);
endmodule

// File: rtl/csw_checker.sv
module csw_checker
  import csw_pkg::*;
#(
  parameter int WAKE_CYC = 4
) (
  input logic       clk,
  input logic       rst,
  input csw_state_e fsm_state,
  input logic       standby_o,
  input logic       wfi_retire_o,
  input logic       debug_state_o,
  input logic       apb_pready_o,
  input logic       dbg_resume_i
);
  localparam int CW = $clog2(WAKE_CYC + 2);
  logic [CW-1:0] wk_q;

  always_ff @(posedge clk) begin
    if (rst)                         wk_q <= '0;
    else if (fsm_state == S_WAKEA)   wk_q <= wk_q + 1'b1;
    else                             wk_q <= '0;
  end

  a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(standby_o && debug_state_o));
  a_r10_retire_pulse: assert property (@(posedge clk) disable iff (rst)
    wfi_retire_o |=> !wfi_retire_o);
  a_r4_no_ready_asleep: assert property (@(posedge clk) disable iff (rst)
    standby_o |-> !apb_pready_o);
  a_r4_wake_len: assert property (@(posedge clk) disable iff (rst)
    (fsm_state == S_SERVE) |-> (wk_q == CW'(WAKE_CYC)));
  a_r4_serve_exit: assert property (@(posedge clk) disable iff (rst)
    (fsm_state == S_SERVE) |=> (standby_o || wfi_retire_o));
  a_r3_retire_to_debug: assert property (@(posedge clk) disable iff (rst)
    (fsm_state == S_RETD) |=> debug_state_o);
  a_r5_retire_to_run: assert property (@(posedge clk) disable iff (rst)
    (fsm_state == S_RETR) |=> (!debug_state_o && !standby_o && !wfi_retire_o));
  a_r7_debug_holds: assert property (@(posedge clk) disable iff (rst)
    (debug_state_o && !dbg_resume_i) |=> debug_state_o);
endmodule

bind core_standby_ctrl csw_checker #(.WAKE_CYC(WAKE_CYC)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .fsm_state     (fsm_state),
  .standby_o     (standby_o),
  .wfi_retire_o  (wfi_retire_o),
  .debug_state_o (debug_state_o),
  .apb_pready_o  (apb_pready_o),
  .dbg_resume_i  (dbg_resume_i)
);

// File: tb/core_standby_ctrl_tb.sv
module core_standby_ctrl_tb;
  localparam int CLK_P = 10;
  localparam int WAKE  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wfi, irq, halt, resume, psel, pen;
  logic pready, stby, retire, dbg;

  always #(CLK_P/2) clk = ~clk;

  core_standby_ctrl #(.WAKE_CYC(WAKE)) u_dut (
    .clk(clk), .rst(rst), .wfi_req_i(wfi), .irq_wake_i(irq),
    .halt_evt_i(halt), .dbg_resume_i(resume), .apb_psel_i(psel),
    .apb_penable_i(pen), .apb_pready_o(pready), .standby_o(stby),
    .wfi_retire_o(retire), .debug_state_o(dbg)
  );

  typedef struct {
    logic [3:0] exp;  // {standby, retire, debug, ready}
    string      tag;
  } item_t;

  item_t q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // monitor: pops one expectation per cycle, between edges
  always @(posedge clk) begin
    #(CLK_P/4);
    if (q.size() > 0) begin
      item_t it;
      logic [3:0] act;
      it  = q.pop_front();
      act = {stby, retire, dbg, pready};
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: {stby,ret,dbg,rdy} actual %b expected %b",
                 it.tag, act, it.exp);
      end
    end
  end

  // driver: in = {wfi, irq, halt, psel, penable, resume}
  task automatic cyc(input logic [5:0] in, input logic [3:0] exp,
                     input string tag);
    item_t it;
    @(negedge clk);
    {wfi, irq, halt, psel, pen, resume} = in;
    it.exp = exp;
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic wait_cycles(input logic [5:0] in, input int n,
                             input logic [3:0] exp, input string tag);
    for (int i = 0; i < n; i++) cyc(in, exp, tag);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    {wfi, irq, halt, psel, pen, resume} = '0;
    // R1: reset state
    cyc(6'b000000, 4'b0000, "R1 in reset");
    cyc(6'b000000, 4'b0000, "R1 in reset");
    rst = 1'b0;
    cyc(6'b000000, 4'b0000, "R1 after reset");

    // R2: enter standby, repeated request ignored
    cyc(6'b100000, 4'b1000, "R2 enter");
    cyc(6'b100000, 4'b1000, "R2 hold");
    cyc(6'b000000, 4'b1000, "R2 hold");

    // R4: debug access in standby -> temporary wake
    cyc(6'b000100, 4'b0000, "R4 wake");
    wait_cycles(6'b000110, WAKE-1, 4'b0000, "R4 stalled");
    cyc(6'b000110, 4'b0001, "R4 ready");
    cyc(6'b000000, 4'b1000, "R4 back to standby");
    cyc(6'b000000, 4'b1000, "R4 no retire");

    // R5: interrupt wake
    cyc(6'b010000, 4'b0000, "R5 wake");
    wait_cycles(6'b000000, WAKE-1, 4'b0000, "R5 waking");
    cyc(6'b000000, 4'b0100, "R5 retire");
    cyc(6'b000000, 4'b0000, "R5 running");

    // R8: access while running
    cyc(6'b000100, 4'b0000, "R8 setup");
    cyc(6'b000110, 4'b0001, "R8 ready");
    cyc(6'b000000, 4'b0000, "R8 idle");

    // R3: halt in standby
    cyc(6'b100000, 4'b1000, "R3 standby");
    cyc(6'b001000, 4'b0000, "R3 leave standby");
    wait_cycles(6'b000000, WAKE-1, 4'b0000, "R3 waking");
    cyc(6'b000000, 4'b0100, "R3 retire");
    cyc(6'b000000, 4'b0010, "R3 debug");

    // R7: standby request ignored in debug; R8 access in debug
    cyc(6'b100000, 4'b0010, "R7 ignore");
    cyc(6'b100000, 4'b0010, "R7 ignore");
    cyc(6'b000100, 4'b0010, "R8 dbg setup");
    cyc(6'b000110, 4'b0011, "R8 dbg ready");
    cyc(6'b000000, 4'b0010, "R8 dbg idle");
    cyc(6'b000001, 4'b0000, "R7 resume");

    // R6: halt and access together
    cyc(6'b100000, 4'b1000, "R6 standby");
    cyc(6'b001100, 4'b0000, "R6 halt wins");
    wait_cycles(6'b000110, WAKE-1, 4'b0000, "R6 waking");
    cyc(6'b000110, 4'b0100, "R6 retire");
    cyc(6'b000110, 4'b0010, "R6 debug");
    cyc(6'b000110, 4'b0011, "R6 ready in debug");
    cyc(6'b000000, 4'b0010, "R6 idle");
    cyc(6'b000001, 4'b0000, "R6 resume");

    // R9: halt during temporary wake
    cyc(6'b100000, 4'b1000, "R9 standby");
    cyc(6'b000100, 4'b0000, "R9 wake");
    cyc(6'b001110, 4'b0000, "R9 halt mid-wake");
    wait_cycles(6'b000110, WAKE-2, 4'b0000, "R9 waking");
    cyc(6'b000110, 4'b0001, "R9 ready");
    cyc(6'b000000, 4'b0100, "R9 retire no standby");
    cyc(6'b000000, 4'b0010, "R9 debug");
    cyc(6'b000001, 4'b0000, "R9 resume");

    // R10 covered by retire-only-one-cycle checks above
    cyc(6'b000000, 4'b0000, "R10 quiet");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule